// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block prepares two external, active-low interrupt pins for a CPU core. One pin carries a non-maskable request. The other carries a maskable request. Both pins are asynchronous, so each passes through a synchronizer clocked by the bus clock. The block then drives registered request outputs to the core.

The maskable path has two modes. It can follow the low level of the pin, or it can latch a single falling edge and hold it until software acknowledges it. The non-maskable path stays gated after reset until software unmasks it once. After that it cannot be masked again.

While the device is in stop mode there is no bus clock. A combinational wakeup output is therefore driven directly from the raw pins. No glitch filtering is applied anywhere in the block.

Top module: `extIrqCond`

## Requirements
- R1: After reset the non-maskable mask is set. `nmiReq` stays 0 whatever `nmiPinN` does until `nmiUnmask` has been pulsed.
- R2: Once unmasked, `nmiReq` goes to 1 while the synchronized `nmiPinN` is low, and returns to 0 when the pin is high. The latency is three clock edges.
- R3: After the mask has been cleared, no input sets it again. A repeated `nmiUnmask` pulse has no effect, and a low `nmiPinN` keeps producing a request.
- R4: Reset clears the maskable enable, so `irqPinN` produces no `irqReq`.
- R5: `irqReq` is 1 only while the enable bit is 1 and `cpuIMask` is 0. When `cpuIMask` is 1, a pending condition is held back.
- R6: A configuration write (`cfgWrite`) loads the enable from `cfgEnable` and the mode from `cfgEdgeSel`. With `cfgEdgeSel` = 0 (level mode), `irqReq` follows the synchronized low level of `irqPinN`.
- R7: With `cfgEdgeSel` = 1 (edge mode), a synchronized falling edge of `irqPinN` is latched. `irqReq` stays 1 after the pin returns high.
- R8: A one-cycle `edgeAck` pulse clears the latched edge. `irqReq` falls within two clock edges. If a new falling edge arrives in the same cycle, the new edge wins.
- R9: A write that clears the enable drops `irqReq` on the same clock edge that stores the write. The same write discards any latched edge, so re-enabling without a new edge gives no request.
- R10: `wakeup` is combinational and is 0 outside stop mode. While `stopMode` is 1, `wakeup` is 1 if `nmiPinN` is low with the non-maskable mask cleared, or if `irqPinN` is low with the maskable enable set.
- R11: There is no filter. A low pulse on `irqPinN` lasting one clock period is enough to latch an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| nmiPinN | input | 1 | Raw non-maskable request pin, active low |
| irqPinN | input | 1 | Raw maskable request pin, active low |
| stopMode | input | 1 | High while the device is in stop mode |
| cpuIMask | input | 1 | CPU maskable-interrupt mask bit |
| nmiUnmask | input | 1 | Pulse that clears the non-maskable mask |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgEnable | input | 1 | Maskable enable value written |
| cfgEdgeSel | input | 1 | Mode written: 1 edge, 0 level |
| edgeAck | input | 1 | Write-one-to-clear for the latched edge |
| nmiReq | output | 1 | Non-maskable request to the core |
| irqReq | output | 1 | Maskable request to the core |
| wakeup | output | 1 | Stop-mode wakeup indication |

## Verification
The assertions assume that the control strobes (`cfgWrite`, `nmiUnmask`, `edgeAck`) are synchronous to `clk`. They also assume that `stopMode` does not toggle during a clock edge at which a request is being checked. The bench drives every input on the falling clock edge. It holds each pin level long enough to cross the synchronizer before it samples anything, except in the one-period pulse case, where the pulse is deliberately aligned to cover exactly one rising edge.

// File: rtl/extIrqPkg.sv
package extIrqPkg;
  localparam int NUM_PINS = 2;
  localparam int NMI_IDX  = 0;
  localparam int IRQ_IDX  = 1;

  typedef struct packed {
    logic nmiMasked;
    logic irqEnable;
    logic edgeMode;
    logic ackEdge;
  } irqStrobesT;
endpackage

// File: rtl/extIrqCtrl.sv
module extIrqCtrl
  import extIrqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       nmiUnmask,
  input  logic       cfgWrite,
  input  logic       cfgEnable,
  input  logic       cfgEdgeSel,
  input  logic       edgeAck,
  output irqStrobesT strobes
);
  logic xMask;
  logic irqEn;
  logic edgeSel;

  // Non-maskable mask: set by reset, cleared once, never set again.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          xMask <= 1'b1;
    else if (nmiUnmask) xMask <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn   <= 1'b0;
      edgeSel <= 1'b0;
    end else if (cfgWrite) begin
      irqEn   <= cfgEnable;
      edgeSel <= cfgEdgeSel;
    end
  end

  always_comb begin
    strobes.nmiMasked = xMask;
    strobes.irqEnable = irqEn;
    strobes.edgeMode  = edgeSel;
    strobes.ackEdge   = edgeAck;
  end

  assert_mask_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    !xMask |=> !xMask);
  assert_enable_loads_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (irqEn == $past(cfgEnable)));
endmodule

// File: rtl/extIrqDatapath.sv
module extIrqDatapath
  import extIrqPkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       nmiPinN,
  input  logic       irqPinN,
  input  logic       stopMode,
  input  logic       cpuIMask,
  input  irqStrobesT strobes,
  output logic       nmiReq,
  output logic       irqReq,
  output logic       wakeup
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] rawPins;
  logic [NUM_PINS-1:0] syncPins;
  logic                irqPrev;
  logic                irqFall;
  logic                edgeFlag;
  logic                nmiReqQ;
  logic                irqReqQ;
  logic                irqCond;

  assign rawPins[NMI_IDX] = nmiPinN;
  assign rawPins[IRQ_IDX] = irqPinN;

  // One synchronizer chain per pin. Each chain resets to the inactive
  // (high) level.
  for (genvar g = 0; g < NUM_PINS; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawPins[g]};
    end
    assign syncPins[g] = chain[TOP];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPrev <= 1'b1;
    else       irqPrev <= syncPins[IRQ_IDX];
  end
  assign irqFall = irqPrev & ~syncPins[IRQ_IDX];

  // Latched edge. A disable clears it. A new falling edge takes
  // priority over an acknowledge arriving in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               edgeFlag <= 1'b0;
    else if (!strobes.irqEnable)             edgeFlag <= 1'b0;
    else if (strobes.edgeMode && irqFall)    edgeFlag <= 1'b1;
    else if (strobes.ackEdge)                edgeFlag <= 1'b0;
  end

  assign irqCond = strobes.edgeMode ? edgeFlag : ~syncPins[IRQ_IDX];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiReqQ <= 1'b0;
      irqReqQ <= 1'b0;
    end else begin
      nmiReqQ <= ~strobes.nmiMasked & ~syncPins[NMI_IDX];
      irqReqQ <= strobes.irqEnable & ~cpuIMask & irqCond;
    end
  end

  assign nmiReq = nmiReqQ;
  // Gating with the live enable drops the request on the same edge as
  // the disabling write.
  assign irqReq = irqReqQ & strobes.irqEnable;

  // Stop-mode path: built from the raw pins, needs no clock.
  assign wakeup = stopMode &
                  ((~nmiPinN & ~strobes.nmiMasked) | (~irqPinN & strobes.irqEnable));

  assert_nmi_gated_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.nmiMasked |-> !nmiReq);
  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.irqEnable |-> !irqReq);
  assert_disable_clears_edge_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.irqEnable |=> !edgeFlag);
  assert_wake_only_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    !stopMode |-> !wakeup);
  assert_level_mode_no_latch_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.edgeMode && !edgeFlag) |=> !edgeFlag);
endmodule

// File: rtl/extIrqCond.sv
module extIrqCond
  import extIrqPkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic clk,
  input  logic rstN,
  input  logic nmiPinN,
  input  logic irqPinN,
  input  logic stopMode,
  input  logic cpuIMask,
  input  logic nmiUnmask,
  input  logic cfgWrite,
  input  logic cfgEnable,
  input  logic cfgEdgeSel,
  input  logic edgeAck,
  output logic nmiReq,
  output logic irqReq,
  output logic wakeup
);
  irqStrobesT strobes;

  extIrqCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .nmiUnmask  (nmiUnmask),
    .cfgWrite   (cfgWrite),
    .cfgEnable  (cfgEnable),
    .cfgEdgeSel (cfgEdgeSel),
    .edgeAck    (edgeAck),
    .strobes    (strobes)
  );

  extIrqDatapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .nmiPinN  (nmiPinN),
    .irqPinN  (irqPinN),
    .stopMode (stopMode),
    .cpuIMask (cpuIMask),
    .strobes  (strobes),
    .nmiReq   (nmiReq),
    .irqReq   (irqReq),
    .wakeup   (wakeup)
  );
endmodule

// File: tb/test_extIrqCond.sv
module test_extIrqCond;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiPinN = 1'b1, irqPinN = 1'b1, stopMode = 1'b0, cpuIMask = 1'b0;
  logic nmiUnmask = 1'b0, cfgWrite = 1'b0, cfgEnable = 1'b0, cfgEdgeSel = 1'b0;
  logic edgeAck = 1'b0;
  logic nmiReq, irqReq, wakeup;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extIrqCond i_extIrqCond (
    .clk(clk), .rstN(rstN), .nmiPinN(nmiPinN), .irqPinN(irqPinN),
    .stopMode(stopMode), .cpuIMask(cpuIMask), .nmiUnmask(nmiUnmask),
    .cfgWrite(cfgWrite), .cfgEnable(cfgEnable), .cfgEdgeSel(cfgEdgeSel),
    .edgeAck(edgeAck), .nmiReq(nmiReq), .irqReq(irqReq), .wakeup(wakeup)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic en, input logic edgeMode);
    cfgWrite = 1'b1; cfgEnable = en; cfgEdgeSel = edgeMode;
    tick(1);
    cfgWrite = 1'b0;
  endtask

  task automatic pulseIrq();
    irqPinN = 1'b0; tick(1); irqPinN = 1'b1;
  endtask

  task automatic testReset();
    check(nmiReq, 1'b0, "R1 nmiReq at reset");
    check(irqReq, 1'b0, "R4 irqReq at reset");
    check(wakeup, 1'b0, "R10 wakeup at reset");
  endtask

  task automatic testNmiMasked();
    nmiPinN = 1'b0; tick(5);
    check(nmiReq, 1'b0, "R1 masked nmi");
    stopMode = 1'b1; #1;
    check(wakeup, 1'b0, "R10 masked nmi no wakeup");
    stopMode = 1'b0; nmiPinN = 1'b1; tick(4);
  endtask

  task automatic testNmiUnmask();
    nmiUnmask = 1'b1; tick(1); nmiUnmask = 1'b0;
    nmiPinN = 1'b0; tick(4);
    check(nmiReq, 1'b1, "R2 nmi low");
    nmiPinN = 1'b1; tick(4);
    check(nmiReq, 1'b0, "R2 nmi high");
    nmiUnmask = 1'b1; tick(1); nmiUnmask = 1'b0;
    nmiPinN = 1'b0; tick(4);
    check(nmiReq, 1'b1, "R3 still unmasked");
    nmiPinN = 1'b1; tick(4);
  endtask

  task automatic testIrqIgnored();
    irqPinN = 1'b0; tick(5);
    check(irqReq, 1'b0, "R4 disabled irq");
    irqPinN = 1'b1; tick(4);
  endtask

  task automatic testLevel();
    writeCfg(1'b1, 1'b0);
    cpuIMask = 1'b1; irqPinN = 1'b0; tick(4);
    check(irqReq, 1'b0, "R5 masked by cpuIMask");
    cpuIMask = 1'b0; tick(3);
    check(irqReq, 1'b1, "R6 level request");
    irqPinN = 1'b1; tick(4);
    check(irqReq, 1'b0, "R6 level released");
  endtask

  task automatic testEdge();
    writeCfg(1'b1, 1'b1);
    pulseIrq(); tick(5);
    check(irqReq, 1'b1, "R7 edge latched");
    check(irqReq, 1'b1, "R11 one-period pulse");
    edgeAck = 1'b1; tick(1); edgeAck = 1'b0; tick(2);
    check(irqReq, 1'b0, "R8 ack clears");
  endtask

  task automatic testDisable();
    pulseIrq(); tick(5);
    check(irqReq, 1'b1, "R9 pending before disable");
    writeCfg(1'b0, 1'b1);
    check(irqReq, 1'b0, "R9 drop on disable");
    writeCfg(1'b1, 1'b1); tick(3);
    check(irqReq, 1'b0, "R9 latched edge discarded");
  endtask

  task automatic testWakeup();
    stopMode = 1'b1;
    nmiPinN = 1'b0; #1;
    check(wakeup, 1'b1, "R10 nmi wakeup");
    nmiPinN = 1'b1; irqPinN = 1'b0; #1;
    check(wakeup, 1'b1, "R10 irq wakeup");
    tick(1);
    writeCfg(1'b0, 1'b0); #1;
    check(wakeup, 1'b0, "R10 disabled irq no wakeup");
    stopMode = 1'b0; irqPinN = 1'b1; #1;
    check(wakeup, 1'b0, "R10 outside stop");
  endtask

  initial begin
    fork
      begin
        tick(3); rstN = 1'b1; tick(1);
        testReset();
        testNmiMasked();
        testIrqIgnored();
        testNmiUnmask();
        testLevel();
        testEdge();
        testDisable();
        testWakeup();
      end
      begin
        tick(5000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule